// File: doc/BRIEF.md
# Baud Divisor Search Engine

This block picks settings for a two-stage baud divider. One stage divides the reference clock by a prescale count `P` (the `bdiv` value). The other stage divides again by `G` (the `bgen` value). The bit rate produced is `ref_hz / (G * (P + 1))`.

A single-cycle `start_i` pulse captures the reference frequency and the requested baud rate. The engine then tries the prescale values in ascending order. For each one it derives `G` by truncating integer division, and it keeps the first pair whose achieved rate is within 3 percent of the request. Both divisions share one iterative restoring divider that produces one quotient bit per cycle.

When the search ends, `done_o` pulses for one cycle. At the same moment `bdiv_o`, `bgen_o` and `found_o` take their new values, and they hold those values until the next search ends. When the reference clock is slow, the request is first limited so that the search still has a usable target.

Top module: `baud_search`

## Requirements
- R1: When `ref_hz_i` is below 1000000 and `baud_i` is above 4800 at start, the search uses 4800 as the target rate. Otherwise it uses `baud_i` unchanged.
- R2: Candidate prescale values `P` are visited in ascending order from 4 to 254. The search stops at the first candidate that is accepted.
- R3: For each candidate, `G = ref_hz / (target * (P + 1))`, using truncating integer division.
- R4: A candidate with `G < 2` or `G > 65535` is rejected without an error test.
- R5: A candidate whose `G` is in range is accepted only if `floor(|target - ref_hz/(G*(P+1))| * 100 / target) < 3`. The achieved-rate division also truncates, and an error of exactly 3 percent is rejected.
- R6: If no candidate is accepted, the outputs report `bdiv_o = 254` and the `G` computed for 254, with `found_o` low.
- R7: `found_o` is high after a search exactly when a candidate was accepted.
- R8: `done_o` is a one-cycle pulse. It goes high after `1 + sum(c_k)` rising edges, counted from the edge that samples `start_i`. Here `c_k` is `DIV_W + 2` for a candidate rejected by R4 and `2*DIV_W + 4` for a candidate that reaches the error test (`DIV_W = 48` by default).
- R9: The operands are captured at start. A `start_i` pulse, or a change on `ref_hz_i` or `baud_i`, while a search is running has no effect on the result or its timing.
- R10: `bdiv_o`, `bgen_o` and `found_o` change only in the cycle where `done_o` is high.
- R11: After reset, `done_o` and `found_o` are low and `bdiv_o` and `bgen_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, used only when idle |
| ref_hz_i | input | CLK_W (32) | Reference clock frequency in Hz |
| baud_i | input | BAUD_W (32) | Requested bit rate |
| done_o | output | 1 | One-cycle pulse at the end of a search |
| found_o | output | 1 | The last search met the error bound |
| bdiv_o | output | BDIV_W (8) | Chosen prescale value |
| bgen_o | output | CLK_W (32) | Chosen generator count |

## Verification
The result is due a number of cycles after start that depends on the data, not a fixed latency. The bench computes it from the same walk over the candidates that gives the expected pair: `DIV_W+2` edges for each candidate rejected by its range and `2*DIV_W+4` edges for each candidate that reaches the error test, plus one edge. After each start, the bench counts rising edges and samples at the falling edge that follows. The first cycle with `done_o` high must fall on exactly the predicted count, and the three outputs are compared in that cycle. In every sampled cycle before it, the outputs must still hold the previous result.

// File: rtl/baud_search_pkg.sv
package baud_search_pkg;
  localparam int unsigned BDIV_FIRST    = 4;
  localparam int unsigned BDIV_LAST     = 254;
  localparam int unsigned BGEN_MIN      = 2;
  localparam int unsigned BGEN_MAX      = 65535;
  localparam int unsigned SLOW_HZ       = 1000000;
  localparam int unsigned SLOW_BAUD_CAP = 4800;
  localparam int unsigned ERR_PCT       = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD_GEN,
    ST_WAIT_GEN,
    ST_LOAD_ACH,
    ST_WAIT_ACH,
    ST_FINISH
  } search_st_e;
endpackage

// File: rtl/bs_divider.sv
module bs_divider #(
  parameter int unsigned W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W:0]    rem_q;
  logic [W-1:0]  quo_q;
  logic [W-1:0]  dvs_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  logic [W:0]    shifted;
  logic          fits;
  logic [W:0]    rem_nxt;

  always_comb begin
    shifted = {rem_q[W-1:0], quo_q[W-1]};
    fits    = shifted >= {1'b0, dvs_q};
    rem_nxt = fits ? (shifted - {1'b0, dvs_q}) : shifted;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        rem_q  <= '0;
        quo_q  <= dividend_i;
        dvs_q  <= divisor_i;
        cnt_q  <= CW'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= rem_nxt;
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = quo_q;

  AST_DIV_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R8
  AST_DIV_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q); // R8
  AST_DIV_BUSY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q); // R8
endmodule

// File: rtl/bs_err_check.sv
module bs_err_check #(
  parameter int unsigned BAUD_W = 32,
  parameter int unsigned W      = 48,
  parameter int unsigned PCT    = 3
) (
  input  logic [BAUD_W-1:0] target_i,
  input  logic [W-1:0]      achieved_i,
  output logic              accept_o
);
  localparam int unsigned EW = W + 8;

  logic [EW-1:0] tgt, ach, diff;

  // floor(diff*100/tgt) < PCT  <=>  diff*100 < PCT*tgt
  always_comb begin
    tgt      = EW'(target_i);
    ach      = EW'(achieved_i);
    diff     = (tgt > ach) ? (tgt - ach) : (ach - tgt);
    accept_o = (diff * EW'(100)) < (tgt * EW'(PCT));
  end
endmodule

// File: rtl/baud_search.sv
module baud_search
  import baud_search_pkg::*;
#(
  parameter int unsigned CLK_W  = 32,
  parameter int unsigned BAUD_W = 32,
  parameter int unsigned BDIV_W = 8,
  parameter int unsigned DIV_W  = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CLK_W-1:0]  ref_hz_i,
  input  logic [BAUD_W-1:0] baud_i,
  output logic              done_o,
  output logic              found_o,
  output logic [BDIV_W-1:0] bdiv_o,
  output logic [CLK_W-1:0]  bgen_o
);
  search_st_e        st_q;
  logic [CLK_W-1:0]  ref_q;
  logic [BAUD_W-1:0] tgt_q;
  logic [BDIV_W-1:0] bdiv_q;
  logic [CLK_W-1:0]  bgen_q;
  logic [BDIV_W-1:0] res_bdiv_q;
  logic [CLK_W-1:0]  res_bgen_q;
  logic              res_found_q;

  logic              div_start, div_busy, div_done;
  logic [DIV_W-1:0]  div_dividend, div_divisor, div_quot;
  logic [DIV_W-1:0]  stage_mult;
  logic              gen_in_range, accept, last_bdiv;
  logic [BAUD_W-1:0] tgt_clamped;

  always_comb begin
    tgt_clamped = ((ref_hz_i < CLK_W'(SLOW_HZ)) && (baud_i > BAUD_W'(SLOW_BAUD_CAP)))
                  ? BAUD_W'(SLOW_BAUD_CAP) : baud_i;
    stage_mult   = DIV_W'(bdiv_q) + DIV_W'(1);
    div_start    = (st_q == ST_LOAD_GEN) || (st_q == ST_LOAD_ACH);
    div_dividend = DIV_W'(ref_q);
    div_divisor  = (st_q == ST_LOAD_GEN) ? DIV_W'(tgt_q) * stage_mult
                                         : DIV_W'(bgen_q) * stage_mult;
    gen_in_range = (div_quot >= DIV_W'(BGEN_MIN)) && (div_quot <= DIV_W'(BGEN_MAX));
    last_bdiv    = bdiv_q == BDIV_W'(BDIV_LAST);
  end

  bs_divider #(.W(DIV_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .dividend_i (div_dividend),
    .divisor_i  (div_divisor),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

  bs_err_check #(.BAUD_W(BAUD_W), .W(DIV_W), .PCT(ERR_PCT)) u_err (
    .target_i   (tgt_q),
    .achieved_i (div_quot),
    .accept_o   (accept)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      ref_q       <= '0;
      tgt_q       <= '0;
      bdiv_q      <= '0;
      bgen_q      <= '0;
      res_bdiv_q  <= '0;
      res_bgen_q  <= '0;
      res_found_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            ref_q  <= ref_hz_i;
            tgt_q  <= tgt_clamped;
            bdiv_q <= BDIV_W'(BDIV_FIRST);
            st_q   <= ST_LOAD_GEN;
          end
        end
        ST_LOAD_GEN: st_q <= ST_WAIT_GEN;
        ST_WAIT_GEN: begin
          if (div_done) begin
            // quotient never exceeds ref_hz, so CLK_W bits hold it
            bgen_q <= div_quot[CLK_W-1:0];
            if (gen_in_range) begin
              st_q <= ST_LOAD_ACH;
            end else if (last_bdiv) begin
              res_bdiv_q  <= bdiv_q;
              res_bgen_q  <= div_quot[CLK_W-1:0];
              res_found_q <= 1'b0;
              st_q        <= ST_FINISH;
            end else begin
              bdiv_q <= bdiv_q + 1'b1;
              st_q   <= ST_LOAD_GEN;
            end
          end
        end
        ST_LOAD_ACH: st_q <= ST_WAIT_ACH;
        ST_WAIT_ACH: begin
          if (div_done) begin
            if (accept || last_bdiv) begin
              res_bdiv_q  <= bdiv_q;
              res_bgen_q  <= bgen_q;
              res_found_q <= accept;
              st_q        <= ST_FINISH;
            end else begin
              bdiv_q <= bdiv_q + 1'b1;
              st_q   <= ST_LOAD_GEN;
            end
          end
        end
        ST_FINISH: st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o  = st_q == ST_FINISH;
  assign found_o = res_found_q;
  assign bdiv_o  = res_bdiv_q;
  assign bgen_o  = res_bgen_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(bdiv_o) && $stable(bgen_o) && $stable(found_o))); // R10
  AST_FOUND_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && found_o) |-> (bgen_o >= CLK_W'(BGEN_MIN) && bgen_o <= CLK_W'(BGEN_MAX))); // R4
  AST_SLOW_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && ref_q < CLK_W'(SLOW_HZ)) |-> (tgt_q <= BAUD_W'(SLOW_BAUD_CAP))); // R1
  AST_BDIV_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |-> (bdiv_q >= BDIV_W'(BDIV_FIRST) && bdiv_q <= BDIV_W'(BDIV_LAST))); // R2
  AST_BDIV_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(div_start) && st_q == ST_LOAD_GEN && $past(st_q) != ST_IDLE)
      |-> (bdiv_q == $past(bdiv_q) + 1'b1)); // R2
  AST_NOTFOUND_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !found_o) |-> (bdiv_o == BDIV_W'(BDIV_LAST))); // R6
  AST_ACH_AFTER_GEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOAD_ACH) |-> !div_busy); // R3
endmodule

// File: tb/baud_search_tb.sv
module baud_search_tb;
  localparam int W = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ref_hz = '0;
  logic [31:0] baud = '0;
  logic        done, found;
  logic [7:0]  bdiv;
  logic [31:0] bgen;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  baud_search u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .ref_hz_i (ref_hz),
    .baud_i   (baud),
    .done_o   (done),
    .found_o  (found),
    .bdiv_o   (bdiv),
    .bgen_o   (bgen)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected result and done latency from the requirements
  function automatic void model(input longint rf, input longint bd,
                                output longint e_bdiv, output longint e_bgen,
                                output bit e_found, output longint e_cyc);
    longint t = (rf < 1000000 && bd > 4800) ? 4800 : bd; // R1
    e_found = 1'b0;
    e_cyc   = 1;
    e_bdiv  = 0;
    e_bgen  = 0;
    for (longint d = 4; d <= 254; d++) begin
      longint g = rf / (t * (d + 1)); // R3
      longint a, e;
      e_bdiv = d;
      e_bgen = g;
      if (g < 2 || g > 65535) begin // R4
        e_cyc += W + 2;
        continue;
      end
      e_cyc += 2 * W + 4;
      a = rf / (g * (d + 1));
      e = (t > a) ? t - a : a - t;
      if ((e * 100) / t < 3) begin // R5
        e_found = 1'b1;
        break;
      end
    end
  endfunction

  task automatic run_case(input longint rf, input longint bd, input bit disturb, input string tag);
    longint e_bdiv, e_bgen, e_cyc;
    bit e_found;
    logic [7:0]  p_bdiv;
    logic [31:0] p_bgen;
    logic        p_found;
    bit held = 1'b1;
    bit got = 1'b0;
    longint n = 0;
    model(rf, bd, e_bdiv, e_bgen, e_found, e_cyc);
    @(negedge clk);
    p_bdiv = bdiv; p_bgen = bgen; p_found = found;
    ref_hz = rf[31:0];
    baud = bd[31:0];
    start = 1'b1;
    while (n < 40000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 1'b0;
      if (disturb && n == 30) begin // R9: ignored while running
        start = 1'b1;
        ref_hz = 32'd7;
        baud = 32'd123456;
      end
      if (done) begin
        got = 1'b1;
        break;
      end
      if (bdiv !== p_bdiv || bgen !== p_bgen || found !== p_found) held = 1'b0;
    end
    start = 1'b0;
    chk(got && n == e_cyc, {"R8 latency ", tag}, n, e_cyc);
    chk(held, {"R10 hold ", tag}, longint'(held), 1);
    chk(bdiv == e_bdiv[7:0], {"R2 bdiv ", tag}, longint'(bdiv), e_bdiv);
    chk(bgen == e_bgen[31:0], {"R3 bgen ", tag}, longint'(bgen), e_bgen);
    chk(found == e_found, {"R7 found ", tag}, longint'(found), longint'(e_found));
    @(negedge clk);
    chk(!done, {"R8 pulse ", tag}, longint'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    longint tbl[8] = '{300, 1200, 9600, 19200, 38400, 57600, 115200, 230400};
    void'($urandom(32'd20481));
    repeat (3) @(negedge clk);
    chk(!done && !found, "R11 reset flags", longint'({done, found}), 0);
    chk(bdiv == 0 && bgen == 0, "R11 reset values", longint'(bgen) + bdiv, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_case(100000000, 115200, 1'b0, "R2 typical");
    run_case(500000, 115200, 1'b0, "R1 clamp slow");
    run_case(999999, 4801, 1'b0, "R1 clamp edge");
    run_case(999999, 4800, 1'b0, "R1 no clamp at cap");
    run_case(1000000, 9600, 1'b0, "R1 fast ref");
    run_case(1020, 100, 1'b0, "R5 under bound");
    run_case(1030, 100, 1'b0, "R5 exact 3pct rejected");
    run_case(100, 9, 1'b0, "R6 no pair");
    run_case(64'd4000000000, 1, 1'b0, "R4 all over range");
    run_case(100000000, 300, 1'b0, "R4 first over range");
    run_case(50000000, 38400, 1'b1, "R9 start while busy");

    for (int i = 0; i < 18; i++) begin
      longint rf = 1000000 + longint'($urandom % 99000000);
      longint bd;
      if (i % 2 == 0) bd = tbl[$urandom % 8];
      else bd = 300 + longint'($urandom % 32'(rf / 20 - 300));
      run_case(rf, bd, i % 5 == 0, "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule